// File: doc/BRIEF.md
# Egg and Burst Dot-Matrix Renderer

This block paints a single target onto an 8x8 red dot matrix that is refreshed one row at a time. The panel is treated as a 4x4 grid of target slots, each slot covering a 2x2 square of dots, and the slot grid matches the physical layout of a 4x4 keypad so that a key press and a slot share one index. While a target ("egg") is visible, its four dots are lit in the row being scanned.

When the surrounding game logic reports a hit, the block latches the slot and replaces the egg with a burst: the dots that border the 2x2 square on its four sides light up, spreading the image outward by one ring. Dots of the ring that would fall outside the panel are dropped. The burst stays for a parameterised number of scan frames; the slot then stays dark until the egg-visible flag is lowered and raised again for the next egg. The block scans rows itself from a row-advance tick supplied by a divider elsewhere.

Top module: `egg_burst_matrix`

## Requirements
- R1: During and right after reset, row 0 is selected, no red dot is lit and no burst is in progress.
- R2: Each cycle with `scan_tick` high moves the scanned row from r to (r+1) mod 8; `row_sel_n` drives bit r low and all other bits high.
- R3: `grn_col` is always all zeros; only red is used.
- R4: Slot k has its top-left dot at row 2*(k>>2), column 2*(k&3); `red_col` bit c drives column c. While an egg is shown, the scanned row lights exactly the egg dots in that row, following `slot_idx` live.
- R5: A `burst_pulse` while an egg is shown starts a burst at the slot on `slot_idx` in that cycle; later changes of `slot_idx` do not move the burst.
- R6: A burst lights the two dots directly above the square, the two directly below, and the two on each side of it; the square itself and the four diagonal corner dots stay dark.
- R7: Burst dots falling outside rows 0..7 or columns 0..7 are not shown; the rest of the ring is unchanged.
- R8: A burst ends on the scan tick leaving row 7 for the BURST_FRAMES-th time after it started; the display then stays blank until `egg_on` has been low for at least one cycle and is high again.
- R9: A `burst_pulse` has no effect when `egg_on` is low, when the egg is already spent, or during a burst; with `egg_on` low and no burst the matrix is blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_idx | input | 4 | Slot of the current egg, 0..15 |
| egg_on | input | 1 | Egg is present |
| burst_pulse | input | 1 | One-cycle hit indication |
| scan_tick | input | 1 | Advance to the next row |
| row_sel_n | output | 8 | Active-low row select, bit r = row r |
| red_col | output | 8 | Red dots of scanned row, bit c = column c |
| grn_col | output | 8 | Green dots, held off |

## Verification
A wrong row counter shows at `row_sel_n` on the very next scan tick, and every row pattern checked after that lands on the wrong row. A wrong latched burst slot or a lost spent flag appears in `red_col` within one frame, as a ring in the wrong place or an egg reappearing after its burst. A burst frame counter that is off by one shows up as a ring that lasts one frame too long or too short, seen at the frame boundary. Slots in a corner, on an edge and in the interior are all drawn in both modes, so clipping faults on any side are exposed.

// File: rtl/egg_burst_matrix.sv
module egg_burst_matrix #(
  parameter int BURST_FRAMES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] slot_idx,
  input  logic       egg_on,
  input  logic       burst_pulse,
  input  logic       scan_tick,
  output logic [7:0] row_sel_n,
  output logic [7:0] red_col,
  output logic [7:0] grn_col
);
  localparam int FW = $clog2(BURST_FRAMES + 1);

  logic [2:0]    row_q;
  logic          burst_q, spent_q;
  logic [3:0]    bslot_q;
  logic [FW-1:0] frames_q;

  wire frame_end = scan_tick && (row_q == 3'd7);
  wire shown     = egg_on && !spent_q && !burst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q    <= '0;
      burst_q  <= 1'b0;
      spent_q  <= 1'b0;
      bslot_q  <= '0;
      frames_q <= '0;
    end else begin
      if (scan_tick) row_q <= row_q + 3'd1;
      if (burst_q && frame_end) begin
        frames_q <= frames_q - 1'b1;
        if (frames_q == FW'(1)) burst_q <= 1'b0;
      end else if (shown && burst_pulse) begin
        burst_q  <= 1'b1;
        spent_q  <= 1'b1;
        bslot_q  <= slot_idx;
        frames_q <= FW'(BURST_FRAMES);
      end
      if (!egg_on) spent_q <= 1'b0;
    end
  end

  wire [3:0] disp_slot = burst_q ? bslot_q : slot_idx;
  wire [3:0] r0        = {1'b0, disp_slot[3:2], 1'b0};
  wire [2:0] c0        = {disp_slot[1:0], 1'b0};
  wire [3:0] row4      = {1'b0, row_q};
  wire       in_body   = (row4 == r0) || (row4 == r0 + 4'd1);
  wire       in_cap    = (row4 + 4'd1 == r0) || (row4 == r0 + 4'd2);
  wire [7:0] pair      = 8'b0000_0011 << c0;
  wire [9:0] side10    = 10'b00_0000_1001 << c0;
  wire [7:0] side      = side10[8:1];

  assign row_sel_n = ~(8'b0000_0001 << row_q);
  assign grn_col   = '0;
  assign red_col   = burst_q ? (in_body ? side : (in_cap ? pair : 8'h00))
                   : shown   ? (in_body ? pair : 8'h00)
                   : 8'h00;

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && row_sel_n[7]) |=> (row_sel_n == {$past(row_sel_n[6:0]), 1'b1}));
  // R2
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && !row_sel_n[7]) |=> (row_sel_n == 8'hFE));
  // R5
  burst_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_q && $past(burst_q)) |-> $stable(bslot_q));
  // R9
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_q) |-> $past(egg_on && burst_pulse));
  // R8
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_q) |-> $past(scan_tick && !row_sel_n[7]));
  // R9
  blank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!egg_on && !burst_q) |-> (red_col == 8'h00));
endmodule

// File: tb/egg_burst_matrix_bench.sv
module egg_burst_matrix_bench;
  localparam int BF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] slot_idx = '0;
  logic       egg_on = 1'b0, burst_pulse = 1'b0, scan_tick = 1'b0, tick_en = 1'b0;
  logic [7:0] row_sel_n, red_col, grn_col;

  egg_burst_matrix #(.BURST_FRAMES(BF)) u_egg_burst_matrix (
    .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .egg_on(egg_on),
    .burst_pulse(burst_pulse), .scan_tick(scan_tick),
    .row_sel_n(row_sel_n), .red_col(red_col), .grn_col(grn_col));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit started = 0, done = 0;
  int m_row = 0, m_frames = 0, m_bslot = 0;
  bit m_burst = 0, m_spent = 0, m_rst = 1;

  function automatic logic [7:0] egg_row(int k, int r);
    logic [7:0] v = '0;
    int r0 = 2 * (k / 4), c0 = 2 * (k % 4);
    for (int c = 0; c < 8; c++)
      if ((r == r0 || r == r0 + 1) && (c == c0 || c == c0 + 1)) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] ring_row(int k, int r);
    logic [7:0] v = '0;
    int r0 = 2 * (k / 4), c0 = 2 * (k % 4);
    for (int c = 0; c < 8; c++) begin
      if ((r == r0 - 1 || r == r0 + 2) && (c == c0 || c == c0 + 1)) v[c] = 1'b1;
      if ((r == r0 || r == r0 + 1) && (c == c0 - 1 || c == c0 + 2)) v[c] = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (!rst_n) begin
      m_row = 0; m_burst = 0; m_spent = 0; m_frames = 0; m_rst = 1;
    end else begin
      m_rst = 0;
      if (m_burst && scan_tick && m_row == 7) begin
        m_frames--;
        if (m_frames == 0) m_burst = 0;
      end else if (egg_on && !m_spent && !m_burst && burst_pulse) begin
        m_burst = 1; m_spent = 1; m_bslot = int'(slot_idx); m_frames = BF;
      end
      if (!egg_on) m_spent = 0;
      if (scan_tick) m_row = (m_row + 1) % 8;
    end
  end

  always @(posedge clk) begin
    #1;
    scan_tick = tick_en ? ~scan_tick : 1'b0;
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (row %0d)", tag, act, exp, m_row);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      logic [7:0] exp_red;
      string tag;
      int k;
      if (m_burst) begin
        k = m_bslot;
        exp_red = ring_row(k, m_row);
        if (int'(slot_idx) != k) tag = "R5";
        else if (k / 4 == 0 || k / 4 == 3 || k % 4 == 0 || k % 4 == 3) tag = "R7";
        else tag = "R6";
      end else if (egg_on && !m_spent) begin
        exp_red = egg_row(int'(slot_idx), m_row);
        tag = "R4";
      end else begin
        exp_red = 8'h00;
        tag = m_rst ? "R1" : (m_spent ? "R8" : "R9");
      end
      check(m_rst ? "R1" : "R2", row_sel_n, ~(8'h01 << m_row));
      check("R3", grn_col, 8'h00);
      check(tag, red_col, exp_red);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic hit();
    @(posedge clk); #2 burst_pulse = 1'b1;
    @(posedge clk); #2 burst_pulse = 1'b0;
  endtask

  task automatic play(int k);
    slot_idx = 4'(k); egg_on = 1'b1;
    step(18);
    hit();
    step(6);
    slot_idx = 4'(15 - k);
    hit();
    step(40);
    egg_on = 1'b0;
    step(3);
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(2);
    tick_en = 1'b1;
    hit();
    step(20);
    play(0);
    play(5);
    play(6);
    play(7);
    play(13);
    play(15);
    play(10);
    egg_on = 1'b1; slot_idx = 4'd9;
    step(30);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule